// File: doc/BRIEF.md
# UART Interrupt Request Combiner

This block gathers the four interrupt conditions of a serial UART into one active-low interrupt request line. Each condition has its own mask bit. It also presents four status bits that host software can poll: receive data waiting, transmit buffer ready, parity of the oldest received word, and a shared bit. The shared bit reports line activity while the UART is powered down and a framing error while it is running.

The transmit condition is not a level. It is captured when the transmit buffer goes from busy to empty while its mask is on, and it is released by the strobe that ends a host data read. The receive line is resynchronised before it is watched for activity. The masks are registered, so a new mask value acts one cycle after it is presented. The receive shifter, the FIFO storage, baud timing and the host serial port lie outside the block and drive its inputs directly.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `irq_n` is 0 exactly when a source is active and its mask bit, registered one cycle earlier, is 1. Mask bit 0 is data available, bit 1 is transmit, bit 2 is parity and bit 3 is the shared bit.
- R2: `st_data` equals `fifo_not_empty`. While it is 1 with mask bit 0 set, `irq_n` stays low.
- R3: `st_parity` is 1 only when `parity_en` is 1 and `fifo_head_parity` is 1, and is 0 otherwise.
- R4: `st_tx_ready` equals `tx_empty` at all times, whether or not the transmit source is latched or cleared.
- R5: The transmit source latches on a 0-to-1 change of `tx_empty` when mask bit 1 is set. Setting the mask while the buffer is already empty, or an edge that happens while the mask is 0, latches nothing.
- R6: A `read_done` pulse clears the transmit source. If a new empty edge arrives in the same cycle, the latch stays set.
- R7: While `shutdown` is 1, `st_shared` shows RX activity. It sets once a change of `rx_line` has passed the SYNC_STAGES synchronizer, which is SYNC_STAGES+1 cycles after the change.
- R8: Leaving shutdown clears the RX-activity latch.
- R9: While `shutdown` is 0, `st_shared` shows the framing flag. A `frame_done` pulse with `frame_stop_ok`=0 sets the flag and one with `frame_stop_ok`=1 clears it. `frame_done` has no effect during shutdown.
- R10: Synchronous reset clears every latched source and the registered masks, and forces `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial receive line |
| shutdown | input | 1 | Low-power mode select |
| parity_en | input | 1 | Parity enable |
| fifo_not_empty | input | 1 | Receive FIFO holds unread data |
| fifo_head_parity | input | 1 | Parity bit received with the oldest FIFO word |
| tx_empty | input | 1 | Transmit buffer can accept data |
| frame_done | input | 1 | Pulse: a character finished |
| frame_stop_ok | input | 1 | First stop bit of that character was 1 |
| read_done | input | 1 | Pulse: a host data read has ended |
| mask_i | input | 4 | Mask bits {shared, parity, transmit, data} |
| irq_n | output | 1 | Interrupt request, active low |
| st_data | output | 1 | Data available status |
| st_tx_ready | output | 1 | Transmit ready status |
| st_parity | output | 1 | Oldest word parity status |
| st_shared | output | 1 | RX activity (shutdown) or framing error (operating) |

## Verification
The bench sweeps every mask value against every data, parity and parity-enable pattern. A wrong bit order or a missing parity-enable gate would show up as `irq_n` disagreeing with the model. It raises the transmit mask while the buffer is already empty, because a level-sensitive design would fire at that point. It also checks that `st_tx_ready` stays high after a read clears the latch, and that a new empty edge beats the clear when both arrive in the same cycle. It checks RX activity exactly at the end of the synchronizer delay, where a design that skipped the synchronizer would report one cycle early. It puts a framing error through shutdown entry and exit, where a design that shared one latch between the two meanings would lose or mix the flag, and then releases it with a good frame.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 4;

    // Bit order is fixed by the mask port: data is bit 0, shared is bit 3.
    typedef struct packed {
        logic shared;
        logic parity;
        logic tx;
        logic data;
    } irq_vec_t;

    function automatic logic any_pending(irq_vec_t src, irq_vec_t msk);
        return |(src & msk);
    endfunction

endpackage

// File: rtl/uart_irq_rxact.sv
module uart_irq_rxact #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    input  logic shutdown,
    output logic activity
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   act_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= rx_line;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            act_q  <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
            if (!shutdown)
                act_q <= 1'b0;
            else if (sync_q[LAST] != prev_q)
                act_q <= 1'b1;
        end
    end

    assign activity = act_q;
endmodule

// File: rtl/uart_irq_frame.sv
module uart_irq_frame (
    input  logic clk,
    input  logic rst,
    input  logic shutdown,
    input  logic frame_done,
    input  logic frame_stop_ok,
    output logic frame_err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (frame_done && !shutdown)
            err_q <= !frame_stop_ok;
    end

    assign frame_err = err_q;
endmodule

// File: rtl/uart_irq_txlatch.sv
module uart_irq_txlatch (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic mask_tx,
    input  logic read_done,
    output logic tx_src
);
    logic empty_d;
    logic src_q;
    logic empty_edge;

    assign empty_edge = tx_empty && !empty_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_d <= 1'b1;
            src_q   <= 1'b0;
        end else begin
            empty_d <= tx_empty;
            if (empty_edge && mask_tx)
                src_q <= 1'b1;
            else if (read_done)
                src_q <= 1'b0;
        end
    end

    assign tx_src = src_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_line,
    input  logic               shutdown,
    input  logic               parity_en,
    input  logic               fifo_not_empty,
    input  logic               fifo_head_parity,
    input  logic               tx_empty,
    input  logic               frame_done,
    input  logic               frame_stop_ok,
    input  logic               read_done,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_n,
    output logic               st_data,
    output logic               st_tx_ready,
    output logic               st_parity,
    output logic               st_shared
);
    irq_vec_t mask_q;
    irq_vec_t src;
    logic     tx_src;
    logic     rx_act;
    logic     frame_err;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= irq_vec_t'(mask_i);
    end

    uart_irq_rxact #(.SYNC_STAGES(SYNC_STAGES)) u_rxact (
        .clk      (clk),
        .rst      (rst),
        .rx_line  (rx_line),
        .shutdown (shutdown),
        .activity (rx_act)
    );

    uart_irq_frame u_frame (
        .clk           (clk),
        .rst           (rst),
        .shutdown      (shutdown),
        .frame_done    (frame_done),
        .frame_stop_ok (frame_stop_ok),
        .frame_err     (frame_err)
    );

    uart_irq_txlatch u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_empty  (tx_empty),
        .mask_tx   (mask_q.tx),
        .read_done (read_done),
        .tx_src    (tx_src)
    );

    always_comb begin
        src.data   = fifo_not_empty;
        src.tx     = tx_src;
        src.parity = parity_en && fifo_head_parity;
        src.shared = shutdown ? rx_act : frame_err;
    end

    assign irq_n       = !any_pending(src, mask_q);
    assign st_data     = src.data;
    assign st_tx_ready = tx_empty;
    assign st_parity   = src.parity;
    assign st_shared   = src.shared;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_empty,
    input logic       read_done,
    input logic [3:0] mask_i,
    input logic [3:0] mask_q,
    input logic       fifo_not_empty,
    input logic       shutdown,
    input logic       frame_done,
    input logic       frame_stop_ok,
    input logic       irq_n,
    input logic       st_shared,
    input logic       tx_src,
    input logic       rx_act
);
    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1)
            p_reset_quiet_r10: assert (irq_n === 1'b1);
    end

    p_data_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (fifo_not_empty && $past(mask_i[0] && !rst)) |-> !irq_n);

    p_tx_edge_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !$past(tx_empty) && $past(!rst) && mask_q[1]) |=> tx_src);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (read_done && tx_empty && $past(tx_empty)) |=> !tx_src);

    p_exit_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(shutdown) |=> !rx_act);

    p_frame_err_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !shutdown && !frame_stop_ok) |=> (shutdown || st_shared));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_empty       (tx_empty),
    .read_done      (read_done),
    .mask_i         (mask_i),
    .mask_q         (mask_q),
    .fifo_not_empty (fifo_not_empty),
    .shutdown       (shutdown),
    .frame_done     (frame_done),
    .frame_stop_ok  (frame_stop_ok),
    .irq_n          (irq_n),
    .st_shared      (st_shared),
    .tx_src         (tx_src),
    .rx_act         (rx_act)
);

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
    localparam int SYNC = 2;
    // {fifo_not_empty, fifo_head_parity, parity_en}
    localparam logic [2:0] PAT [8] = '{3'b000, 3'b100, 3'b010, 3'b001,
                                       3'b011, 3'b110, 3'b101, 3'b111};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1, shutdown = 1'b0, parity_en = 1'b0;
    logic fifo_not_empty = 1'b0, fifo_head_parity = 1'b0, tx_empty = 1'b1;
    logic frame_done = 1'b0, frame_stop_ok = 1'b1, read_done = 1'b0;
    logic [3:0] mask_i = 4'b0000;
    logic irq_n, st_data, st_tx_ready, st_parity, st_shared;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl #(.SYNC_STAGES(SYNC)) u_uart_irq_ctrl (
        .clk(clk), .rst(rst), .rx_line(rx_line), .shutdown(shutdown),
        .parity_en(parity_en), .fifo_not_empty(fifo_not_empty),
        .fifo_head_parity(fifo_head_parity), .tx_empty(tx_empty),
        .frame_done(frame_done), .frame_stop_ok(frame_stop_ok),
        .read_done(read_done), .mask_i(mask_i), .irq_n(irq_n),
        .st_data(st_data), .st_tx_ready(st_tx_ready),
        .st_parity(st_parity), .st_shared(st_shared)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R10 reset state
        check("R10 irq_n in reset", irq_n, 1'b1);
        check("R4 tx ready in reset", st_tx_ready, 1'b1);
        rst = 1'b0;
        tick(2);
        check("R10 irq_n after reset", irq_n, 1'b1);
        check("R9 shared clear after reset", st_shared, 1'b0);

        // R1 R2 R3 table sweep over all masks
        for (int p = 0; p < 8; p++) begin
            fifo_not_empty   = PAT[p][2];
            fifo_head_parity = PAT[p][1];
            parity_en        = PAT[p][0];
            for (int m = 0; m < 16; m++) begin
                mask_i = 4'(m);
                tick(1);
                check("R1 irq_n mask sweep", irq_n,
                      !((mask_i[0] && PAT[p][2]) ||
                        (mask_i[2] && PAT[p][1] && PAT[p][0])));
            end
            check("R2 st_data", st_data, PAT[p][2]);
            check("R3 st_parity", st_parity, PAT[p][1] && PAT[p][0]);
        end

        // R1 one-cycle mask latency
        fifo_not_empty = 1'b1; parity_en = 1'b0; mask_i = 4'b0000;
        tick(1);
        mask_i = 4'b0001;
        #1;
        check("R1 mask not yet active", irq_n, 1'b1);
        tick(1);
        check("R2 data irq", irq_n, 1'b0);
        fifo_not_empty = 1'b0;
        #1;
        check("R2 data drained", irq_n, 1'b1);

        // R5 busy-to-empty edge latches
        mask_i = 4'b0010; tick(1);
        tx_empty = 1'b0; tick(1);
        check("R4 busy not ready", st_tx_ready, 1'b0);
        tx_empty = 1'b1; tick(1);
        check("R5 edge sets tx irq", irq_n, 1'b0);
        // R6 read clears
        read_done = 1'b1; tick(1); read_done = 1'b0;
        check("R6 read clears tx irq", irq_n, 1'b1);
        check("R4 still ready after clear", st_tx_ready, 1'b1);
        // R6 set beats clear
        tx_empty = 1'b0; tick(1);
        tx_empty = 1'b1; read_done = 1'b1; tick(1); read_done = 1'b0;
        check("R6 edge wins over read", irq_n, 1'b0);
        read_done = 1'b1; tick(1); read_done = 1'b0;
        check("R6 second read clears", irq_n, 1'b1);
        // R5 edge with mask off, then mask on while empty
        mask_i = 4'b0000; tick(1);
        tx_empty = 1'b0; tick(1);
        tx_empty = 1'b1; tick(1);
        mask_i = 4'b0010; tick(2);
        check("R5 no latch without edge", irq_n, 1'b1);

        // R9 framing error
        mask_i = 4'b1000; tick(1);
        frame_done = 1'b1; frame_stop_ok = 1'b0; tick(1); frame_done = 1'b0;
        check("R9 bad frame sets", st_shared, 1'b1);
        check("R9 bad frame irq", irq_n, 1'b0);
        frame_done = 1'b1; frame_stop_ok = 1'b1; tick(1); frame_done = 1'b0;
        check("R9 good frame clears", st_shared, 1'b0);
        check("R9 irq released", irq_n, 1'b1);
        frame_done = 1'b1; frame_stop_ok = 1'b0; tick(1); frame_done = 1'b0;
        shutdown = 1'b1; tick(1);
        check("R7 shutdown shows activity not error", st_shared, 1'b0);
        frame_done = 1'b1; frame_stop_ok = 1'b1; tick(1); frame_done = 1'b0;
        shutdown = 1'b0; tick(1);
        check("R9 frame ignored in shutdown", st_shared, 1'b1);
        frame_done = 1'b1; frame_stop_ok = 1'b1; tick(1); frame_done = 1'b0;
        check("R9 cleared again", st_shared, 1'b0);

        // R7 RX activity in shutdown
        rx_line = 1'b0; tick(4);
        check("R7 no activity when operating", st_shared, 1'b0);
        rx_line = 1'b1; tick(4);
        shutdown = 1'b1; tick(4);
        check("R7 quiet line", st_shared, 1'b0);
        check("R7 quiet irq", irq_n, 1'b1);
        rx_line = 1'b0; tick(SYNC);
        check("R7 not before sync delay", st_shared, 1'b0);
        tick(1);
        check("R7 activity seen", st_shared, 1'b1);
        check("R7 activity irq", irq_n, 1'b0);
        rx_line = 1'b1; tick(SYNC + 1);
        check("R7 activity held", st_shared, 1'b1);
        shutdown = 1'b0; tick(1);
        check("R8 exit clears", st_shared, 1'b0);
        shutdown = 1'b1; tick(2);
        check("R8 latch gone on re-entry", st_shared, 1'b0);
        shutdown = 1'b0; tick(1);

        // R10 reset mid-activity
        mask_i = 4'b0010; tx_empty = 1'b0; tick(1);
        tx_empty = 1'b1; tick(1);
        check("R5 latched before reset", irq_n, 1'b0);
        rst = 1'b1; tick(1);
        check("R10 reset drops irq", irq_n, 1'b1);
        rst = 1'b0; tick(2);
        check("R10 latch cleared by reset", irq_n, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule